// File: doc/BRIEF.md
# SPI Status-Bit Autopoll Engine

This block takes a repetitive device status wait, such as waiting for a flash memory to leave its busy state, away from software. Once started, it runs a series of tries. Each try is one framed SPI transaction: chip select goes high, a command byte is sent, one response byte is read, and chip select is released. One selected bit of the response is compared with an expected level. The poll ends on the first match. It also ends after a try limit that grows with the SPI clock setting and a timeout field.

Software writes a single configuration word. That word holds the command byte, the bit position, the expected level, the timeout field and a go bit. The byte exchanges themselves are requested from a shared SPI master through a request/acknowledge handshake. The engine reports the end of each try, a successful match and a timeout as three sticky status bits. Software clears a status bit by writing 1 to it. Each status bit can be kept from raising the interrupt line by a mask bit.

Top module: `spi_autopoll`

## Requirements
- R1: After reset the configuration readback is zero, all status bits are zero, and the interrupt, request and chip select outputs are low.
- R2: A configuration write with bit 31 set while idle starts a poll, and bit 31 of the readback stays 1 until the poll ends. While idle, every write updates the readback fields: command in bits 7:0, timeout in bits 19:16, bit position in bits 26:24, expected level in bit 30. All other readback bits are zero.
- R3: Each try holds chip select high for exactly two byte exchanges, then drops it for at least one cycle. The first exchange sends the command byte and the second sends 0x00. The request is only high while chip select is high.
- R4: The response of the second exchange is tested at the position from bits 26:24 against bit 30. A match ends the poll and sets status bit 1.
- R5: The try limit is 31 shifted left by the sum of the clock setting input and the timeout field. When that many tries have run without a match, status bit 2 is set and the poll ends.
- R6: Status bit 0 is set at the end of every try, including the final one.
- R7: A configuration write with bit 31 clear during a poll ends it after the current try. Neither status bit 1 nor status bit 2 is set.
- R8: A configuration write during a poll changes none of the readback fields. A write with bit 31 set does not restart the poll.
- R9: Writing 1 to a status clear bit clears that status bit. Writing 0 to a status clear bit leaves that status bit unchanged.
- R10: The interrupt output pulses high for one cycle, in the same cycle the status changes, when a status bit goes from 0 to 1 and its mask bit is 0. A masked status bit is still recorded.
- R11: The byte received during the command exchange has no effect on the match decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write data |
| cfg_rdata | output | 32 | Configuration readback, bit 31 is busy |
| clk_sel | input | 3 | SPI clock setting, scales the try limit |
| mask_wr_en | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 3 | Mask bits, 1 blocks the matching status bit |
| stat_clr_en | input | 1 | Status clear strobe |
| stat_clr_data | input | 3 | Write-one-to-clear bits for the status |
| irq_stat | output | 3 | Status: 0 try end, 1 match, 2 timeout |
| irq | output | 1 | Interrupt pulse |
| xfer_req | output | 1 | Byte exchange request to the SPI master |
| xfer_cs | output | 1 | Chip select for the current try |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | One-cycle pulse marking exchange done |
| xfer_rx | input | 8 | Received byte, valid with xfer_ack |

## Verification
The bench drives the response bit to the expected level during the command exchange. A design that tested the wrong byte would then stop on the first try instead of the scheduled one. Timeouts run at three combinations of clock setting and timeout field. A design that added the two fields wrongly, or counted one try too many or too few, would show a different number of responses served. An abort in the middle of a poll and a restart write during a poll confirm that an abort produces no result bit and that fields cannot move under a running poll. Mask settings of all, none and only the try-end bit separate the recorded status from the interrupt pulses, counted per run.

// File: rtl/spi_autopoll_pkg.sv
package spi_autopoll_pkg;
  // configuration word layout
  localparam int CMD_LSB  = 0;
  localparam int TMO_LSB  = 16;
  localparam int BSEL_LSB = 24;
  localparam int POL_BIT  = 30;
  localparam int GO_BIT   = 31;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_HIT  = 1;
  localparam int ST_TMO  = 2;
  localparam int ST_W    = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_RSP  = 2'd2,
    SQ_END  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ap_try_limit.sv
module ap_try_limit #(
  parameter int CLK_W    = 3,
  parameter int TMO_W    = 4,
  parameter int TRY_BASE = 31,
  localparam int BASE_W  = $clog2(TRY_BASE + 1),
  localparam int MAX_SH  = (2**CLK_W - 1) + (2**TMO_W - 1),
  localparam int SH_W    = $clog2(MAX_SH + 1),
  localparam int CNT_W   = BASE_W + MAX_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CLK_W-1:0] clk_sel,
  input  logic [TMO_W-1:0] tmo,
  input  logic             try_end,
  output logic             last_try
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] tries_q;
  logic [SH_W-1:0]  shift;

  assign shift = SH_W'(clk_sel) + SH_W'(tmo);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      tries_q <= '0;
    end else if (start) begin
      limit_q <= CNT_W'(TRY_BASE) << shift;
      tries_q <= '0;
    end else if (try_end) begin
      tries_q <= tries_q + CNT_W'(1);
    end
  end

  // the try now ending is the final one allowed
  assign last_try = (tries_q == limit_q - CNT_W'(1));
endmodule

// File: rtl/ap_seq.sv
module ap_seq
  import spi_autopoll_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort_req,
  input  logic              last_try,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BIT_W-1:0]  bsel,
  input  logic              pol,
  input  logic              xfer_ack,
  input  logic [BYTE_W-1:0] xfer_rx,
  output logic              busy,
  output logic              try_end,
  output logic [ST_W-1:0]   ev,
  output logic              xfer_req,
  output logic              xfer_cs,
  output logic [BYTE_W-1:0] xfer_tx
);
  seq_state_t state_q;
  logic       abort_q;
  logic       hit_q;
  logic       finish;

  assign try_end = (state_q == SQ_END);
  assign finish  = abort_q || hit_q || last_try;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start) state_q <= SQ_CMD;
        SQ_CMD:  if (xfer_ack) state_q <= SQ_RSP;
        SQ_RSP:  if (xfer_ack) begin
                   hit_q   <= (xfer_rx[bsel] == pol);
                   state_q <= SQ_END;
                 end
        SQ_END:  state_q <= finish ? SQ_IDLE : SQ_CMD;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            abort_q <= 1'b0;
    else if (start)     abort_q <= 1'b0;
    else if (abort_req) abort_q <= 1'b1;
  end

  always_comb begin
    ev          = '0;
    ev[ST_DONE] = try_end;
    ev[ST_HIT]  = try_end && !abort_q && hit_q;
    ev[ST_TMO]  = try_end && !abort_q && !hit_q && last_try;
  end

  assign busy     = (state_q != SQ_IDLE);
  assign xfer_req = (state_q == SQ_CMD) || (state_q == SQ_RSP);
  assign xfer_cs  = xfer_req;
  assign xfer_tx  = (state_q == SQ_CMD) ? cmd : '0;
endmodule

// File: rtl/ap_irq.sv
module ap_irq
  import spi_autopoll_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] ev,
  input  logic            clr_en,
  input  logic [ST_W-1:0] clr_data,
  input  logic            mask_wr_en,
  input  logic [ST_W-1:0] mask_wdata,
  output logic [ST_W-1:0] stat,
  output logic            irq
);
  logic [ST_W-1:0] mask_q;
  logic [ST_W-1:0] clr_vec;
  logic [ST_W-1:0] stat_nxt;

  assign clr_vec  = clr_en ? clr_data : '0;
  assign stat_nxt = (stat & ~clr_vec) | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      irq    <= 1'b0;
      mask_q <= '0;
    end else begin
      stat <= stat_nxt;
      irq  <= |(stat_nxt & ~stat & ~mask_q);
      if (mask_wr_en) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/spi_autopoll.sv
module spi_autopoll
  import spi_autopoll_pkg::*;
#(
  parameter int CLK_W    = 3,
  parameter int TMO_W    = 4,
  parameter int BYTE_W   = 8,
  parameter int TRY_BASE = 31,
  localparam int BIT_W   = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [CLK_W-1:0]  clk_sel,
  input  logic              mask_wr_en,
  input  logic [ST_W-1:0]   mask_wdata,
  input  logic              stat_clr_en,
  input  logic [ST_W-1:0]   stat_clr_data,
  output logic [ST_W-1:0]   irq_stat,
  output logic              irq,
  output logic              xfer_req,
  output logic              xfer_cs,
  output logic [BYTE_W-1:0] xfer_tx,
  input  logic              xfer_ack,
  input  logic [BYTE_W-1:0] xfer_rx
);
  logic [BYTE_W-1:0] cmd_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [BIT_W-1:0]  bsel_q;
  logic              pol_q;
  logic              busy;
  logic              start;
  logic              abort_req;
  logic              try_end;
  logic              last_try;
  logic [ST_W-1:0]   ev;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;
  assign start     = cfg_wr_en && !busy && cfg_wdata[GO_BIT];
  assign abort_req = cfg_wr_en && busy && !cfg_wdata[GO_BIT];

  // fields are frozen while a poll runs
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      tmo_q  <= '0;
      bsel_q <= '0;
      pol_q  <= 1'b0;
    end else if (cfg_wr_en && !busy) begin
      cmd_q  <= cfg_wdata[CMD_LSB +: BYTE_W];
      tmo_q  <= cfg_wdata[TMO_LSB +: TMO_W];
      bsel_q <= cfg_wdata[BSEL_LSB +: BIT_W];
      pol_q  <= cfg_wdata[POL_BIT];
    end
  end

  always_comb begin
    cfg_rdata                       = '0;
    cfg_rdata[CMD_LSB +: BYTE_W]    = cmd_q;
    cfg_rdata[TMO_LSB +: TMO_W]     = tmo_q;
    cfg_rdata[BSEL_LSB +: BIT_W]    = bsel_q;
    cfg_rdata[POL_BIT]              = pol_q;
    cfg_rdata[GO_BIT]               = busy;
  end

  ap_try_limit #(
    .CLK_W(CLK_W), .TMO_W(TMO_W), .TRY_BASE(TRY_BASE)
  ) u_limit (
    .clk(clk), .rst(rst), .start(start), .clk_sel(clk_sel),
    .tmo(cfg_wdata[TMO_LSB +: TMO_W]), .try_end(try_end), .last_try(last_try)
  );

  ap_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .abort_req(abort_req),
    .last_try(last_try), .cmd(cmd_q), .bsel(bsel_q), .pol(pol_q),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .busy(busy), .try_end(try_end),
    .ev(ev), .xfer_req(xfer_req), .xfer_cs(xfer_cs), .xfer_tx(xfer_tx)
  );

  ap_irq u_irq (
    .clk(clk), .rst(rst), .ev(ev), .clr_en(stat_clr_en),
    .clr_data(stat_clr_data), .mask_wr_en(mask_wr_en),
    .mask_wdata(mask_wdata), .stat(irq_stat), .irq(irq)
  );
endmodule

// File: rtl/spi_autopoll_chk.sv
module spi_autopoll_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [2:0]  irq_stat,
  input logic        irq,
  input logic        xfer_req,
  input logic        xfer_cs
);
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[30:0], cfg_rdata[30:0]};

  a_r3_req_inside_cs: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> xfer_cs);

  a_r1_idle_no_cs: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[31] |-> !xfer_cs);

  a_r2_start_by_write: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_rdata[31]) |-> $past(cfg_wr_en && cfg_wdata[31]));

  a_r4_hit_ends_poll: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat[1]) |-> (!cfg_rdata[31] && irq_stat[0]));

  a_r5_timeout_ends_poll: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat[2]) |-> (!cfg_rdata[31] && irq_stat[0]));

  a_r10_irq_needs_rise: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((irq_stat & ~$past(irq_stat)) != 3'b000));
endmodule

bind spi_autopoll spi_autopoll_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .irq_stat(irq_stat), .irq(irq),
  .xfer_req(xfer_req), .xfer_cs(xfer_cs)
);

// File: tb/sim_spi_autopoll.sv
`timescale 1ns/1ps
module sim_spi_autopoll;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [2:0]  clk_sel = '0;
  logic        mask_wr_en = 1'b0;
  logic [2:0]  mask_wdata = '0;
  logic        stat_clr_en = 1'b0;
  logic [2:0]  stat_clr_data = '0;
  logic [2:0]  irq_stat;
  logic        irq;
  logic        xfer_req;
  logic        xfer_cs;
  logic [7:0]  xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = '0;

  always #2 clk = ~clk;

  spi_autopoll u0 (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .clk_sel(clk_sel), .mask_wr_en(mask_wr_en),
    .mask_wdata(mask_wdata), .stat_clr_en(stat_clr_en),
    .stat_clr_data(stat_clr_data), .irq_stat(irq_stat), .irq(irq),
    .xfer_req(xfer_req), .xfer_cs(xfer_cs), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- responder (the SPI master stand-in) ----------------
  int  rs_dly = 1;
  int  rs_cnt = 0;
  bit  rs_second = 1'b0;
  int  resp_n = 0;
  int  hit_try = 0;
  bit [2:0] t_bsel = '0;
  bit  t_pol = 1'b0;
  int  irq_seen = 0;

  always @(negedge clk) begin
    if (irq) irq_seen++;
    if (!xfer_cs) rs_second = 1'b0;
    if (xfer_ack) begin
      xfer_ack = 1'b0;
      rs_cnt = 0;
    end else if (xfer_req) begin
      if (rs_cnt >= rs_dly) begin
        logic [7:0] b;
        xfer_ack = 1'b1;
        if (!rs_second) begin
          // command exchange: tested bit always looks like a match (R11)
          b = 8'hC3 ^ 8'(resp_n * 37);
          b[t_bsel] = t_pol;
        end else begin
          b = 8'h3C ^ 8'(resp_n * 11);
          b[t_bsel] = (hit_try != 0 && resp_n + 1 == hit_try) ? t_pol : !t_pol;
          resp_n++;
        end
        xfer_rx = b;
        rs_second = !rs_second;
      end else begin
        rs_cnt++;
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  bit       m_busy, m_abort, m_pend, m_hit, m_irq, ob;
  int       m_acks, m_tries, m_limit;
  bit [7:0] m_cmd;
  bit [3:0] m_tmo;
  bit [2:0] m_bsel, m_stat, m_mask, setv, clrv, nxt;
  bit       m_pol;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_abort = 0; m_pend = 0; m_hit = 0; m_irq = 0;
      m_acks = 0; m_tries = 0; m_limit = 0;
      m_cmd = 0; m_tmo = 0; m_bsel = 0; m_pol = 0; m_stat = 0; m_mask = 0;
    end else begin
      ob = m_busy;
      setv = 3'b000;
      if (m_pend) begin
        m_pend = 0;
        m_tries++;
        setv[0] = 1'b1;
        if (m_abort) m_busy = 0;
        else if (m_hit) begin setv[1] = 1'b1; m_busy = 0; end
        else if (m_tries >= m_limit) begin setv[2] = 1'b1; m_busy = 0; end
      end
      clrv = stat_clr_en ? stat_clr_data : 3'b000;
      nxt = (m_stat & ~clrv) | setv;
      m_irq = |(nxt & ~m_stat & ~m_mask);
      m_stat = nxt;
      if (mask_wr_en) m_mask = mask_wdata;
      if (ob && xfer_ack) begin
        m_acks++;
        if (m_acks % 2 == 0) begin
          m_hit = (xfer_rx[m_bsel] == m_pol);
          m_pend = 1;
        end
      end
      if (cfg_wr_en) begin
        if (!ob) begin
          m_cmd = cfg_wdata[7:0]; m_tmo = cfg_wdata[19:16];
          m_bsel = cfg_wdata[26:24]; m_pol = cfg_wdata[30];
          if (cfg_wdata[31]) begin
            m_busy = 1; m_abort = 0; m_acks = 0; m_tries = 0;
            m_limit = 31 << (int'(clk_sel) + int'(cfg_wdata[19:16]));
          end
        end else if (!cfg_wdata[31]) begin
          m_abort = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R2 readback", cfg_rdata,
            {m_busy, m_pol, 3'b000, m_bsel, 4'h0, m_tmo, 8'h00, m_cmd});
      check("R6 status", {29'd0, irq_stat}, {29'd0, m_stat});
      check("R10 irq", {31'd0, irq}, {31'd0, m_irq});
      check("R3 cs", {31'd0, xfer_cs}, {31'd0, (m_busy && !m_pend)});
      check("R3 req", {31'd0, xfer_req}, {31'd0, (m_busy && !m_pend)});
      if (xfer_req)
        check("R3 tx", {24'd0, xfer_tx}, {24'd0, (m_acks % 2 == 0) ? m_cmd : 8'h00});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg_write(bit go, bit [7:0] cmd, bit [3:0] tmo, bit [2:0] bsel, bit pol);
    @(negedge clk);
    cfg_wdata = {go, pol, 3'b101, bsel, 4'hA, tmo, 8'h5A, cmd};
    cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic mask_write(bit [2:0] m);
    @(negedge clk);
    mask_wdata = m; mask_wr_en = 1'b1;
    @(negedge clk);
    mask_wr_en = 1'b0;
  endtask

  task automatic clear_stat(bit [2:0] c);
    @(negedge clk);
    stat_clr_data = c; stat_clr_en = 1'b1;
    @(negedge clk);
    stat_clr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && cfg_rdata[31]; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic poll(bit [7:0] cmd, bit [3:0] tmo, bit [2:0] bsel, bit pol, int hit);
    t_bsel = bsel; t_pol = pol; hit_try = hit; resp_n = 0;
    cfg_write(1'b1, cmd, tmo, bsel, pol);
    wait_idle();
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", cfg_rdata, 32'h0);
    check("R1 reset stat", {29'd0, irq_stat}, 32'h0);
    check("R1 reset irq/cs/req", {29'd0, irq, xfer_cs, xfer_req}, 32'h0);
    cmp_on = 1'b1;

    // R2: idle write, no start
    cfg_write(1'b0, 8'h05, 4'h3, 3'd6, 1'b1);
    check("R2 idle fields", cfg_rdata, 32'h4603_0005);

    // R4, R6, R11: match on third try, clear-bit polling
    rs_dly = 1;
    poll(8'h05, 4'h0, 3'd0, 1'b0, 3);
    check("R4 match status", {29'd0, irq_stat}, 32'h3);
    check("R11 tries before match", resp_n, 3);
    clear_stat(3'b001);
    check("R9 partial clear", {29'd0, irq_stat}, 32'h2);
    clear_stat(3'b010);
    check("R9 full clear", {29'd0, irq_stat}, 32'h0);

    // R10: all masked, match on first try, set-bit polling on bit 7
    mask_write(3'b111);
    irq_seen = 0; rs_dly = 0;
    poll(8'hD7, 4'h2, 3'd7, 1'b1, 1);
    check("R10 masked status recorded", {29'd0, irq_stat}, 32'h3);
    check("R10 masked no irq", irq_seen, 0);
    clear_stat(3'b111);
    mask_write(3'b000);
    irq_seen = 0;
    poll(8'h70, 4'h0, 3'd4, 1'b1, 2);
    check("R10 unmasked pulses", irq_seen, 2);
    clear_stat(3'b111);
    mask_write(3'b001);
    irq_seen = 0; rs_dly = 2;
    poll(8'h70, 4'h0, 3'd2, 1'b0, 2);
    check("R10 try-end masked pulses", irq_seen, 1);
    clear_stat(3'b111);
    mask_write(3'b000);

    // R5: timeout limits
    rs_dly = 0; clk_sel = 3'd0;
    poll(8'h9F, 4'h0, 3'd1, 1'b0, 0);
    check("R5 timeout status", {29'd0, irq_stat}, 32'h5);
    check("R5 tries clk0 tmo0", resp_n, 31);
    clear_stat(3'b111);
    clk_sel = 3'd1;
    poll(8'h9F, 4'h0, 3'd3, 1'b1, 0);
    check("R5 tries clk1 tmo0", resp_n, 62);
    clear_stat(3'b111);
    clk_sel = 3'd0;
    poll(8'h9F, 4'h1, 3'd5, 1'b0, 0);
    check("R5 tries clk0 tmo1", resp_n, 62);
    check("R5 timeout status again", {29'd0, irq_stat}, 32'h5);
    clear_stat(3'b111);

    // R7: abort mid-poll
    rs_dly = 1;
    t_bsel = 3'd2; t_pol = 1'b1; hit_try = 0; resp_n = 0;
    cfg_write(1'b1, 8'h35, 4'h0, 3'd2, 1'b1);
    repeat (12) @(negedge clk);
    cfg_write(1'b0, 8'hEE, 4'hF, 3'd7, 1'b0);
    wait_idle();
    check("R7 abort status", {29'd0, irq_stat}, 32'h1);
    check("R7 abort early", {31'd0, (resp_n >= 1 && resp_n < 10)}, 32'h1);
    clear_stat(3'b111);

    // R8: restart write during poll is ignored
    t_bsel = 3'd3; t_pol = 1'b0; hit_try = 4; resp_n = 0;
    cfg_write(1'b1, 8'hA1, 4'h0, 3'd3, 1'b0);
    repeat (3) @(negedge clk);
    cfg_write(1'b1, 8'h11, 4'h5, 3'd6, 1'b1);
    check("R8 fields frozen", cfg_rdata, 32'h8300_00A1);
    wait_idle();
    check("R8 completes original poll", {29'd0, irq_stat}, 32'h3);
    check("R8 tries", resp_n, 4);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule